// File: doc/BRIEF.md
# Two-Phase Linear Sensor Readout Clock Generator

This block drives the horizontal shift register of a linear charge-coupled sensor. From a fast system clock it makes the two complementary transfer phases, a reset-gate pulse for the sense node, and a strobe that tells an external converter when to sample. Each pixel period is a programmable, even number of system-clock cycles. Phase 1 is high for the first half of each period and low for the second half, and phase 2 is always its inverse. The packet for each pixel reaches the sense node on the falling edge of phase 1. The reset gate pulses high inside the phase-1-high half and returns low no later than that falling edge, so every packet arrives at a freshly reset node.

A line starts with a one-cycle command. The block then clocks out 512, 1024 or 2048 pixels, raises a one-cycle line-done flag and parks: phase 1 high, phase 2 low and the reset gate high. The configuration is captured when a line starts. Settings that are out of range are clamped, so the timing rules always hold.

Top module: `ccd_hclk_gen`

## Requirements
- R1: While reset is held, and in the parked state after reset, ph1=1, ph2=0, rg=1, sample=0, line_done=0 and pix_idx=0.
- R2: The effective pixel period Pe is 4 when pix_period<4, and otherwise pix_period with bit 0 cleared. Let H=Pe/2. In cycle c (0..Pe-1) of a pixel, ph1 is high for c<H and low for c>=H. ph2 is the inverse of ph1 throughout a line.
- R3: rg is high for rise<=c<fall and low for the other cycles of the pixel. fall is rg_off clamped into 1..H, and rise is rg_on, lowered to fall-1 when rg_on>=fall. rg is therefore low in the cycle where ph1 falls.
- R4: sample is high for exactly one cycle per pixel, at c = H + min(SAMPLE_DLY, H-1), with the default SAMPLE_DLY=1. That cycle always falls in the phase-1-low half.
- R5: len_sel codes the line length: 0 gives 512 pixels, 1 gives 1024, and 2 or 3 give 2048. pix_idx shows the current pixel number, running from 0 to N-1.
- R6: line_start is accepted only while parked. On the clock edge that samples it, the outputs already show cycle 0 of pixel 0. While a line is running, line_start has no effect.
- R7: On the edge after the last cycle of pixel N-1, line_done is high for exactly one cycle and the outputs return to the parked state.
- R8: pix_period, rg_on, rg_off and len_sel are captured when a line is accepted. Changing them during a line has no effect on that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Start-of-line command |
| pix_period | input | CNT_W | Pixel period in clock cycles |
| rg_on | input | CNT_W | Reset-gate rise offset within the pixel |
| rg_off | input | CNT_W | Reset-gate fall offset within the pixel |
| len_sel | input | 2 | Line length code |
| ph1 | output | 1 | Transfer phase 1 |
| ph2 | output | 1 | Transfer phase 2 |
| rg | output | 1 | Reset gate |
| sample | output | 1 | Converter sample strobe |
| line_done | output | 1 | One-cycle end-of-line flag |
| pix_idx | output | PIX_W | Current pixel index |

## Verification
Every output is registered from the next-state value of the counters. As a result, cycle k of a line, counted from the edge that samples line_start, shows up on the outputs just after edge k. The line_done flag and the parked levels show up just after edge N*Pe. The driver pushes one expected record for each of those edges into a queue. The monitor pops one record each cycle, 5 ns after every rising edge, so each comparison lands after the register update and well before the next input change. Stimulus that must be ignored is part of the same stream: line_start is held high through a whole line, and the configuration inputs are changed mid-line. The queued records still assume the captured settings.

// File: rtl/ccd_hclk_pkg.sv
package ccd_hclk_pkg;

   typedef enum logic [1:0] {
      LEN_SHORT  = 2'd0,
      LEN_MID    = 2'd1,
      LEN_LONG   = 2'd2,
      LEN_LONG_B = 2'd3
   } len_code_e;

   localparam int unsigned MIN_PERIOD = 4;
   localparam int unsigned MAX_LINE   = 2048;

   function automatic int unsigned line_pixels(input logic [1:0] code);
      case (len_code_e'(code))
         LEN_SHORT: return 512;
         LEN_MID:   return 1024;
         default:   return MAX_LINE;
      endcase
   endfunction

endpackage

// File: rtl/ccd_cfg_capture.sv
module ccd_cfg_capture
   import ccd_hclk_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter int PIX_W      = 12,
   parameter int SAMPLE_DLY = 1,
   parameter bit LATCH_CFG  = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             accept,
   input  logic [CNT_W-1:0] period_i,
   input  logic [CNT_W-1:0] rise_i,
   input  logic [CNT_W-1:0] fall_i,
   input  logic [1:0]       sel_i,
   output logic [CNT_W-1:0] per_q,
   output logic [PIX_W-1:0] last_q,
   output logic [CNT_W-1:0] half_nx,
   output logic [CNT_W-1:0] rise_nx,
   output logic [CNT_W-1:0] fall_nx,
   output logic [CNT_W-1:0] smp_nx
);
   localparam logic [CNT_W-1:0] PMIN = CNT_W'(MIN_PERIOD);
   localparam logic [CNT_W-1:0] SDLY = CNT_W'(SAMPLE_DLY);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   logic [CNT_W-1:0] per_c, half_c, fall_c, rise_c, smp_c, sd_c;
   logic [PIX_W-1:0] last_c;

   always_comb begin
      per_c  = (period_i < PMIN) ? PMIN : {period_i[CNT_W-1:1], 1'b0};
      half_c = per_c >> 1;
      if (fall_i == '0)
         fall_c = ONE;
      else if (fall_i > half_c)
         fall_c = half_c;
      else
         fall_c = fall_i;
      rise_c = (rise_i >= fall_c) ? (fall_c - ONE) : rise_i;
      sd_c   = (SDLY >= half_c) ? (half_c - ONE) : SDLY;
      smp_c  = half_c + sd_c;
      last_c = PIX_W'(line_pixels(sel_i) - 1);
   end

   generate
      if (LATCH_CFG) begin : g_latched
         logic [CNT_W-1:0] half_q, rise_q, fall_q, smp_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               per_q  <= PMIN;
               half_q <= PMIN >> 1;
               rise_q <= '0;
               fall_q <= ONE;
               smp_q  <= PMIN - ONE;
               last_q <= '0;
            end else if (accept) begin
               per_q  <= per_c;
               half_q <= half_c;
               rise_q <= rise_c;
               fall_q <= fall_c;
               smp_q  <= smp_c;
               last_q <= last_c;
            end
         end
         assign half_nx = accept ? half_c : half_q;
         assign rise_nx = accept ? rise_c : rise_q;
         assign fall_nx = accept ? fall_c : fall_q;
         assign smp_nx  = accept ? smp_c  : smp_q;
      end else begin : g_live
         assign per_q   = per_c;
         assign last_q  = last_c;
         assign half_nx = half_c;
         assign rise_nx = rise_c;
         assign fall_nx = fall_c;
         assign smp_nx  = smp_c;
      end
   endgenerate

   // R3: the reset gate must finish before phase 1 falls
   p_rg_order_r3: assert property (@(posedge clk) disable iff (rst)
      (rise_nx < fall_nx) && (fall_nx <= half_nx));
   // R4: the strobe lands inside the phase-1-low half
   p_smp_window_r4: assert property (@(posedge clk) disable iff (rst)
      (smp_nx >= half_nx) && (smp_nx < (half_nx << 1)));

endmodule

// File: rtl/ccd_pix_timer.sv
module ccd_pix_timer #(
   parameter int CNT_W = 8,
   parameter int PIX_W = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [CNT_W-1:0] per,
   input  logic [PIX_W-1:0] last_pix,
   output logic             accept,
   output logic             run_nx,
   output logic [CNT_W-1:0] cyc_nx,
   output logic             done_nx,
   output logic [PIX_W-1:0] pix_q
);
   logic             run_q;
   logic [CNT_W-1:0] cyc_q;
   logic [PIX_W-1:0] pix_nx;
   logic             wrap;

   assign accept = start && !run_q;
   assign wrap   = run_q && (cyc_q == (per - CNT_W'(1)));

   always_comb begin
      run_nx  = run_q;
      cyc_nx  = cyc_q;
      pix_nx  = pix_q;
      done_nx = 1'b0;
      if (accept) begin
         run_nx = 1'b1;
         cyc_nx = '0;
         pix_nx = '0;
      end else if (run_q) begin
         if (wrap) begin
            cyc_nx = '0;
            if (pix_q == last_pix) begin
               run_nx  = 1'b0;
               pix_nx  = '0;
               done_nx = 1'b1;
            end else begin
               pix_nx = pix_q + PIX_W'(1);
            end
         end else begin
            cyc_nx = cyc_q + CNT_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q <= 1'b0;
         cyc_q <= '0;
         pix_q <= '0;
      end else begin
         run_q <= run_nx;
         cyc_q <= cyc_nx;
         pix_q <= pix_nx;
      end
   end

   // R6: a start during a line leaves the pixel index alone
   p_start_ignored_r6: assert property (@(posedge clk) disable iff (rst)
      run_q && start && !wrap |=> run_q && (pix_q == $past(pix_q)));
   // R5: the index never passes the last pixel
   p_pix_bound_r5: assert property (@(posedge clk) disable iff (rst)
      run_q |-> pix_q <= last_pix);
   // R5: the index advances by one at a pixel boundary
   p_pix_step_r5: assert property (@(posedge clk) disable iff (rst)
      wrap && (pix_q != last_pix) |=> pix_q == $past(pix_q) + PIX_W'(1));

endmodule

// File: rtl/ccd_phase_decode.sv
module ccd_phase_decode #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             run_nx,
   input  logic [CNT_W-1:0] cyc_nx,
   input  logic             done_nx,
   input  logic [CNT_W-1:0] half_nx,
   input  logic [CNT_W-1:0] rise_nx,
   input  logic [CNT_W-1:0] fall_nx,
   input  logic [CNT_W-1:0] smp_nx,
   output logic             ph1,
   output logic             ph2,
   output logic             rg,
   output logic             sample,
   output logic             line_done
);
   logic first_half;

   assign first_half = cyc_nx < half_nx;

   always_ff @(posedge clk) begin
      if (rst) begin
         ph1       <= 1'b1;
         ph2       <= 1'b0;
         rg        <= 1'b1;
         sample    <= 1'b0;
         line_done <= 1'b0;
      end else begin
         ph1       <= !run_nx || first_half;
         ph2       <= run_nx && (cyc_nx >= half_nx);
         rg        <= !run_nx || ((cyc_nx >= rise_nx) && (cyc_nx < fall_nx));
         sample    <= run_nx && (cyc_nx == smp_nx);
         line_done <= done_nx;
      end
   end

   // R2: the phases stay complementary
   p_phase_comp_r2: assert property (@(posedge clk) disable iff (rst)
      ph1 != ph2);
   // R3: the gate is already low on the cycle phase 1 falls
   p_rg_low_at_fall_r3: assert property (@(posedge clk) disable iff (rst)
      $fell(ph1) |-> !rg);
   // R4: the strobe only occurs with phase 1 low
   p_sample_low_r4: assert property (@(posedge clk) disable iff (rst)
      sample |-> !ph1);
   // R7: the done flag is a single-cycle pulse
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
      line_done |=> !line_done);
   // R7: the block is parked while done is shown
   p_done_parked_r7: assert property (@(posedge clk) disable iff (rst)
      line_done |-> ph1 && rg && !sample);

endmodule

// File: rtl/ccd_hclk_gen.sv
module ccd_hclk_gen
   import ccd_hclk_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter int PIX_W      = 12,
   parameter int SAMPLE_DLY = 1,
   parameter bit LATCH_CFG  = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             line_start,
   input  logic [CNT_W-1:0] pix_period,
   input  logic [CNT_W-1:0] rg_on,
   input  logic [CNT_W-1:0] rg_off,
   input  logic [1:0]       len_sel,
   output logic             ph1,
   output logic             ph2,
   output logic             rg,
   output logic             sample,
   output logic             line_done,
   output logic [PIX_W-1:0] pix_idx
);
   generate
      if (CNT_W < 3) begin : g_bad_cnt
         $error("CNT_W must hold the minimum period");
      end
      if ((1 << PIX_W) < MAX_LINE) begin : g_bad_pix
         $error("PIX_W too narrow for the longest line");
      end
      if (SAMPLE_DLY < 0 || SAMPLE_DLY >= (1 << (CNT_W - 1))) begin : g_bad_dly
         $error("SAMPLE_DLY out of range");
      end
   endgenerate

   logic             accept, run_nx, done_nx;
   logic [CNT_W-1:0] cyc_nx, per_q, half_nx, rise_nx, fall_nx, smp_nx;
   logic [PIX_W-1:0] last_q;

   ccd_cfg_capture #(
      .CNT_W(CNT_W), .PIX_W(PIX_W),
      .SAMPLE_DLY(SAMPLE_DLY), .LATCH_CFG(LATCH_CFG)
   ) u_cfg (
      .clk(clk), .rst(rst), .accept(accept),
      .period_i(pix_period), .rise_i(rg_on), .fall_i(rg_off), .sel_i(len_sel),
      .per_q(per_q), .last_q(last_q),
      .half_nx(half_nx), .rise_nx(rise_nx), .fall_nx(fall_nx), .smp_nx(smp_nx)
   );

   ccd_pix_timer #(.CNT_W(CNT_W), .PIX_W(PIX_W)) u_tmr (
      .clk(clk), .rst(rst), .start(line_start),
      .per(per_q), .last_pix(last_q),
      .accept(accept), .run_nx(run_nx), .cyc_nx(cyc_nx),
      .done_nx(done_nx), .pix_q(pix_idx)
   );

   ccd_phase_decode #(.CNT_W(CNT_W)) u_dec (
      .clk(clk), .rst(rst),
      .run_nx(run_nx), .cyc_nx(cyc_nx), .done_nx(done_nx),
      .half_nx(half_nx), .rise_nx(rise_nx), .fall_nx(fall_nx), .smp_nx(smp_nx),
      .ph1(ph1), .ph2(ph2), .rg(rg), .sample(sample), .line_done(line_done)
   );

   // R1: reset parks the outputs
   p_reset_park_r1: assert property (@(posedge clk)
      $past(rst) |-> ph1 && !ph2 && rg && !sample && !line_done);

endmodule

// File: tb/sim_ccd_hclk_gen.sv
module sim_ccd_hclk_gen;
   localparam int CW = 8;
   localparam int PW = 12;

   typedef struct packed {
      logic          p1;
      logic          p2;
      logic          g;
      logic          s;
      logic          d;
      logic [PW-1:0] idx;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          line_start = 1'b0;
   logic [CW-1:0] pix_period = 8'd4;
   logic [CW-1:0] rg_on = '0;
   logic [CW-1:0] rg_off = 8'd1;
   logic [1:0]    len_sel = '0;
   logic          ph1, ph2, rg, sample, line_done;
   logic [PW-1:0] pix_idx;

   exp_t exp_q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   string ctx = "";
   bit   finished = 1'b0;

   always #10 clk = ~clk;

   ccd_hclk_gen u0 (
      .clk(clk), .rst(rst), .line_start(line_start),
      .pix_period(pix_period), .rg_on(rg_on), .rg_off(rg_off), .len_sel(len_sel),
      .ph1(ph1), .ph2(ph2), .rg(rg), .sample(sample),
      .line_done(line_done), .pix_idx(pix_idx)
   );

   function automatic exp_t idle_item(input logic done);
      exp_t e;
      e.p1 = 1'b1; e.p2 = 1'b0; e.g = 1'b1; e.s = 1'b0; e.d = done; e.idx = '0;
      return e;
   endfunction

   task automatic report(input exp_t e);
      exp_t a;
      a = '{ph1, ph2, rg, sample, line_done, pix_idx};
      n_chk++;
      if (a !== e) begin
         n_bad++;
         if (a.p1 !== e.p1 || a.p2 !== e.p2)
            $display("FAIL R2 %s phases got %b%b exp %b%b", ctx, a.p1, a.p2, e.p1, e.p2);
         else if (a.g !== e.g)
            $display("FAIL R3 %s rg got %b exp %b", ctx, a.g, e.g);
         else if (a.s !== e.s)
            $display("FAIL R4 %s sample got %b exp %b", ctx, a.s, e.s);
         else if (a.d !== e.d)
            $display("FAIL R7 %s done got %b exp %b", ctx, a.d, e.d);
         else
            $display("FAIL R5 %s idx got %0d exp %0d", ctx, a.idx, e.idx);
      end
   endtask

   // monitor: one record per rising edge, sampled 5 ns after it
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (exp_q.size() > 0) report(exp_q.pop_front());
      end
   end

   // driver: program a line, push every expected record, then scramble inputs
   task automatic run_line(input int sel, input int per, input int rise,
                           input int fall, input bit hold, input string tag);
      int pe, h, fe, re, sd, n, c;
      exp_t e;
      pe = (per < 4) ? 4 : (per & ~1);
      h  = pe / 2;
      fe = (fall == 0) ? 1 : ((fall > h) ? h : fall);
      re = (rise >= fe) ? fe - 1 : rise;
      sd = (1 >= h) ? h - 1 : 1;
      n  = (sel == 0) ? 512 : ((sel == 1) ? 1024 : 2048);
      @(negedge clk);
      ctx = tag;
      pix_period = CW'(per); rg_on = CW'(rise); rg_off = CW'(fall); len_sel = 2'(sel);
      line_start = 1'b1;
      for (int k = 0; k < n * pe; k++) begin
         c = k % pe;
         e.p1 = (c < h); e.p2 = (c >= h);
         e.g = (c >= re) && (c < fe);
         e.s = (c == h + sd);
         e.d = 1'b0;
         e.idx = PW'(k / pe);
         exp_q.push_back(e);
      end
      exp_q.push_back(idle_item(1'b1));
      exp_q.push_back(idle_item(1'b0));
      @(negedge clk);
      // R8: configuration changes after acceptance must not alter the line
      pix_period = 8'd30; rg_on = 8'd0; rg_off = 8'd15; len_sel = 2'd1;
      if (hold) begin
         // R6: start held high through the line is ignored
         repeat (n * pe - 3) @(negedge clk);
      end
      line_start = 1'b0;
      while (exp_q.size() > 0) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: parked levels while reset is held
      ctx = "reset";
      n_chk++;
      if (!(ph1 === 1'b1 && ph2 === 1'b0 && rg === 1'b1 && sample === 1'b0 &&
            line_done === 1'b0 && pix_idx === '0)) begin
         n_bad++;
         $display("FAIL R1 reset got %b%b%b%b%b idx %0d exp 10100 idx 0",
                  ph1, ph2, rg, sample, line_done, pix_idx);
      end
      rst = 1'b0;
      @(negedge clk);
      ctx = "R1 idle";
      report(idle_item(1'b0));
      // R2 R3 R5: shortest period, gate falls right at the phase edge
      run_line(0, 4, 0, 2, 1'b0, "R2 R5 len512 P4");
      // R6 R8: start held, inputs scrambled, odd period rounds to 6
      run_line(1, 7, 1, 2, 1'b1, "R6 R8 len1024 P7");
      // R3: rise and fall offsets clamped, code 2 gives 2048
      run_line(2, 3, 5, 9, 1'b0, "R3 clamp len2048 P3");
      // R4 R7: long period, fall offset zero, code 3 gives 2048
      run_line(3, 10, 0, 0, 1'b0, "R4 R7 code3 P10");
      repeat (2) @(negedge clk);
      ctx = "R7 parked";
      report(idle_item(1'b0));
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired, got hung run exp completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule